// File: doc/BRIEF.md
# SPI Master Clock and Chip-Select Controller

This block is the serial master at the edge of a peripheral subsystem. It turns the core clock into a serial clock according to a packed rate word, supports all four clock-polarity and clock-phase combinations, and moves one byte per transfer, most significant bit first. The rate word has two encodings. One divides by a four-bit mantissa times a power of two. The other divides by an even ratio from 4 to 30.

Up to eight active-low device selects are driven from one control register. A single write carries both the select index and the enable bit, so the lines move in one step. A programmable capture delay places the point where the input line is latched a few core cycles after the nominal sampling edge. This gives read margin in mode 3 at the fastest rate. A completion flag is raised when each byte finishes, and software polls it.

Software drives the block through a flat write/read port. It first sets up the rate, the mode and the capture delay, then asserts a select. Each write to the data address that arrives while a select is asserted and the engine is idle sends one byte. The received byte is read back from that same address.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset every select line is high, `sck`, `mosi` and `irq` are low, the rate register reads 0x0002 and the capture-delay register (address 2, bits [1:0]) reads 1.
- R2: A write to address 0 sets the enable bit (bit 0) and the select index (bits [3:1]). With the enable bit set, exactly the indexed `cs_n` line goes low. With it clear, all lines are high. The lines change only on the cycle after such a write.
- R3: Address 1 holds the divisor mantissa in bits [3:0], the exponent in bits [6:4] and the encoding select in bit 7 (1 = power-of-two encoding). In that encoding the serial clock period is max(mantissa,1)·2^exponent core cycles, and never less than 2.
- R4: With bit 7 clear, the period is 2·h core cycles, where h is bits [3:0] raised to at least 2. The ratio therefore lies between 4 and 30.
- R5: Address 1 bit 8 is the clock polarity, and `sck` rests at that level whenever no byte is in flight. After a start, the first edge comes floor(P/2) core cycles later. Later edges alternate between gaps of ceil(P/2) and floor(P/2), for 16 edges in all.
- R6: Address 1 bit 9 is the clock phase. With it clear, `mosi` presents bit 7 at the start and changes after each trailing edge. With it set, `mosi` changes on each leading edge. Bits go out most significant first.
- R7: The capture delay D (0 to 3) is the number of core cycles after each sampling edge until `miso` is latched. Sampling edges are the leading edges for phase 0 and the trailing edges for phase 1.
- R8: A write to address 3 starts a byte only when the enable bit is set and no byte is in flight. Any other such write has no effect.
- R9: The completion flag (address 4 bit 0, also `irq`) rises in the cycle that ends the later of the 16th edge and the 8th capture. A start clears it.
- R10: A control write that clears the enable bit while a byte is in flight stops the byte at once. `sck` returns to the polarity level and the completion flag is not raised.
- R11: Reading address 3 returns the receive shift register, which holds the full byte after completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the register at `addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 8 | Active-low device selects |
| irq | output | 1 | Completion flag |

## Verification
The delayed capture of the last sampled bit and the final serial clock edge can land in the same core cycle. Either one can also come first, and the completion flag must wait for whichever is later. The bench provokes this by sweeping the capture delay from 0 to 3 across short periods, including odd ones, in every mode. A behavioural model schedules each edge and capture from the start cycle and judges `sck`, `mosi`, `irq` and the read data on every clock. A control write that clears the enable bit can also coincide with an edge. This is judged the same way: the abort wins.

// File: rtl/spi_ctl_pkg.sv
// Shared constants for the serial master: register addresses, field
// positions of the rate word and reset values. Assumes a 16-bit register port.
package spi_ctl_pkg;
    localparam int ADDR_W = 3;
    localparam int REG_W  = 16;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RATE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIME  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAUSE = 3'd4;

    localparam int MANT_W       = 4;
    localparam int EXP_W        = 3;
    localparam int RATE_EXP_LSB = 4;
    localparam int RATE_POW_BIT = 7;
    localparam int RATE_POL_BIT = 8;
    localparam int RATE_PHA_BIT = 9;
    localparam int RATE_W       = 10;

    localparam int DLY_W = 2;
    localparam logic [DLY_W-1:0]  DLY_RESET  = 2'd1;
    localparam logic [RATE_W-1:0] RATE_RESET = 10'h002;

    localparam int LEG_MIN_HALF = 2;

    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_t;
endpackage

// File: rtl/spi_rate_decode.sv
// Rate decoder: turns the packed rate fields into a serial clock period in
// core cycles. Purely combinational. Assumes DIV_W can hold the largest
// mantissa shifted by the largest exponent.
module spi_rate_decode
    import spi_ctl_pkg::*;
#(
    parameter int DIV_W = MANT_W + (2**EXP_W) - 1
) (
    input  logic              pow_mode,
    input  logic [MANT_W-1:0] mant,
    input  logic [EXP_W-1:0]  expo,
    output logic [DIV_W-1:0]  period
);
    localparam logic [DIV_W-1:0] MIN_PERIOD = DIV_W'(2);
    localparam logic [DIV_W-1:0] MIN_HALF   = DIV_W'(LEG_MIN_HALF);

    logic [DIV_W-1:0] mant_ext;
    logic [DIV_W-1:0] shifted;
    logic [DIV_W-1:0] half;

    // Select period from either encoding, clamping each to its legal floor.
    always_comb begin
        mant_ext = (mant == '0) ? DIV_W'(1) : DIV_W'(mant);
        shifted  = mant_ext << expo;
        half     = (DIV_W'(mant) < MIN_HALF) ? MIN_HALF : DIV_W'(mant);
        if (pow_mode) begin
            period = (shifted < MIN_PERIOD) ? MIN_PERIOD : shifted;
        end else begin
            period = half << 1;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Shift engine: generates the serial clock edges for one byte, shifts data
// out MSB first and captures input a programmable number of cycles after each
// sampling edge. Assumes start is only raised while idle and abort only while
// running; period, phase and delay are latched at start.
module spi_shift_engine
    import spi_ctl_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  period,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DLY_W-1:0]  dly,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done_pulse,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES + 1);
    localparam int CAP_W  = $clog2(BYTE_W + 1);
    localparam int TAPS   = 2**DLY_W;
    localparam logic [EDGE_W-1:0] ALL_EDGES = EDGE_W'(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);
    localparam logic [CAP_W-1:0]  ALL_CAPS  = CAP_W'(BYTE_W);

    eng_state_t        state_q;
    logic [DIV_W-1:0]  period_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [EDGE_W-1:0] edge_q;
    logic [CAP_W-1:0]  cap_q;
    logic              cpha_q;
    logic [DLY_W-1:0]  dly_q;
    logic [TAPS-2:0]   pend_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic              sck_q;
    logic              mosi_q;

    logic [DIV_W-1:0]  h1, h2, lim;
    logic              run, edges_left, edge_now, leading;
    logic              sample_now, shift_now, cap_now, finish;
    logic [TAPS-1:0]   tap;
    logic [EDGE_W-1:0] edge_nx;
    logic [CAP_W-1:0]  cap_nx;

    // Decide whether this cycle carries an edge, a shift, a capture or the end.
    always_comb begin
        h1         = period_q >> 1;
        h2         = period_q - h1;
        lim        = edge_q[0] ? h2 : h1;
        run        = (state_q == ENG_RUN);
        edges_left = (edge_q != ALL_EDGES);
        edge_now   = run && edges_left && (cnt_q == lim - DIV_W'(1));
        leading    = ~edge_q[0];
        sample_now = edge_now && (leading != cpha_q);
        shift_now  = edge_now && (cpha_q ? leading : (!leading && edge_q != LAST_EDGE));
        tap        = {pend_q, sample_now};
        cap_now    = run && tap[dly_q];
        edge_nx    = edge_q + EDGE_W'(edge_now);
        cap_nx     = cap_q + CAP_W'(cap_now);
        finish     = run && !abort && (edge_nx == ALL_EDGES) && (cap_nx == ALL_CAPS);
    end

    // Sequence one byte: load on start, step edges and captures, stop on end or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ENG_IDLE;
            period_q <= '0;
            cnt_q    <= '0;
            edge_q   <= '0;
            cap_q    <= '0;
            cpha_q   <= 1'b0;
            dly_q    <= '0;
            pend_q   <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            sck_q    <= 1'b0;
            mosi_q   <= 1'b0;
        end else if (abort) begin
            state_q <= ENG_IDLE;
            sck_q   <= cpol;
            pend_q  <= '0;
        end else if (state_q == ENG_IDLE) begin
            sck_q <= cpol;
            if (start) begin
                state_q  <= ENG_RUN;
                period_q <= period;
                cnt_q    <= '0;
                edge_q   <= '0;
                cap_q    <= '0;
                cpha_q   <= cpha;
                dly_q    <= dly;
                pend_q   <= '0;
                if (cpha) begin
                    tx_q <= tx_byte;
                end else begin
                    tx_q   <= tx_byte << 1;
                    mosi_q <= tx_byte[BYTE_W-1];
                end
            end
        end else begin
            if (edges_left) begin
                cnt_q <= edge_now ? '0 : cnt_q + DIV_W'(1);
            end
            sck_q  <= sck_q ^ edge_now;
            edge_q <= edge_nx;
            cap_q  <= cap_nx;
            pend_q <= tap[TAPS-2:0];
            if (shift_now) begin
                mosi_q <= tx_q[BYTE_W-1];
                tx_q   <= tx_q << 1;
            end
            if (cap_now) begin
                rx_q <= {rx_q[BYTE_W-2:0], miso};
            end
            if (finish) begin
                state_q <= ENG_IDLE;
            end
        end
    end

    assign sck        = sck_q;
    assign mosi       = mosi_q;
    assign busy       = (state_q == ENG_RUN);
    assign done_pulse = finish;
    assign rx_byte    = rx_q;
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank: holds the control, rate and capture-delay registers and the
// completion flag. Drives the selects from one write and issues start and
// abort to the engine. Assumes a single write port and a combinational read mux.
module spi_reg_bank
    import spi_ctl_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              busy,
    input  logic              finish,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [NUM_CS-1:0] cs_n,
    output logic              start,
    output logic              abort,
    output logic [RATE_W-1:0] rate,
    output logic [DLY_W-1:0]  dly,
    output logic              done,
    output logic [REG_W-1:0]  rdata
);
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int CTRL_W   = CS_IDX_W + 1;

    logic [CTRL_W-1:0] ctrl_q;
    logic [RATE_W-1:0] rate_q;
    logic [DLY_W-1:0]  dly_q;
    logic              done_q;
    logic [NUM_CS-1:0] cs_n_q;
    logic [NUM_CS-1:0] cs_n_nx;
    logic              wr_ctrl, wr_data;

    // Decode writes and derive the engine commands.
    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_data = wr_en && (addr == A_DATA);
        start   = wr_data && ctrl_q[0] && !busy;
        abort   = wr_ctrl && !wdata[0] && busy;
    end

    // Build the whole select vector from one write so lines move together.
    always_comb begin
        cs_n_nx = '1;
        for (int i = 0; i < NUM_CS; i++) begin
            if (wdata[0] && (wdata[CS_IDX_W:1] == CS_IDX_W'(i))) begin
                cs_n_nx[i] = 1'b0;
            end
        end
    end

    // Hold the software registers and the select lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rate_q <= RATE_RESET;
            dly_q  <= DLY_RESET;
            cs_n_q <= '1;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    ctrl_q <= wdata[CTRL_W-1:0];
                    cs_n_q <= cs_n_nx;
                end
                A_RATE:  rate_q <= wdata[RATE_W-1:0];
                A_TIME:  dly_q  <= wdata[DLY_W-1:0];
                default: ;
            endcase
        end
    end

    // Completion flag: set when a byte ends, cleared when the next one starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (start) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end
    end

    // Return the addressed register.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = REG_W'(ctrl_q);
            A_RATE:  rdata = REG_W'(rate_q);
            A_TIME:  rdata = REG_W'(dly_q);
            A_DATA:  rdata = REG_W'(rx_byte);
            A_CAUSE: rdata = REG_W'(done_q);
            default: rdata = '0;
        endcase
    end

    assign cs_n = cs_n_q;
    assign rate = rate_q;
    assign dly  = dly_q;
    assign done = done_q;
endmodule

// File: rtl/spi_master_ctl.sv
// Top of the serial master: ties the register bank, the rate decoder and the
// shift engine together. Assumes one core clock and a synchronous
// active-low reset.
module spi_master_ctl
    import spi_ctl_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n,
    output logic              irq
);
    localparam int DIV_W = MANT_W + (2**EXP_W) - 1;

    logic              busy;
    logic              finish;
    logic              xfer_start;
    logic              xfer_abort;
    logic [RATE_W-1:0] rate;
    logic [DLY_W-1:0]  dly;
    logic [DIV_W-1:0]  period;
    logic [BYTE_W-1:0] rx_byte;
    logic              cfg_cpol;

    assign cfg_cpol = rate[RATE_POL_BIT];

    spi_reg_bank #(.NUM_CS(NUM_CS), .BYTE_W(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .busy    (busy),
        .finish  (finish),
        .rx_byte (rx_byte),
        .cs_n    (cs_n),
        .start   (xfer_start),
        .abort   (xfer_abort),
        .rate    (rate),
        .dly     (dly),
        .done    (irq),
        .rdata   (rdata)
    );

    spi_rate_decode #(.DIV_W(DIV_W)) u_rate (
        .pow_mode (rate[RATE_POW_BIT]),
        .mant     (rate[MANT_W-1:0]),
        .expo     (rate[RATE_EXP_LSB +: EXP_W]),
        .period   (period)
    );

    spi_shift_engine #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (xfer_start),
        .abort      (xfer_abort),
        .tx_byte    (wdata[BYTE_W-1:0]),
        .period     (period),
        .cpol       (cfg_cpol),
        .cpha       (rate[RATE_PHA_BIT]),
        .dly        (dly),
        .miso       (miso),
        .sck        (sck),
        .mosi       (mosi),
        .busy       (busy),
        .done_pulse (finish),
        .rx_byte    (rx_byte)
    );
endmodule

// File: rtl/spi_master_ctl_chk.sv
// Checker for the serial master, bound to the top. Observes ports and the
// busy, polarity and start signals between the internal blocks.
module spi_master_ctl_chk
    import spi_ctl_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n,
    input logic              irq,
    input logic              busy,
    input logic              cpol,
    input logic              start
);
    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R2
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && addr == A_CTRL) |-> $stable(cs_n));

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> (sck == $past(cpol)));

    // R9
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!irq && busy));

    // R10
    busy_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(&cs_n));

    // R8
    no_start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA && (&cs_n) && !busy) |=> !busy);
endmodule

bind spi_master_ctl spi_master_ctl_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .sck   (sck),
    .cs_n  (cs_n),
    .irq   (irq),
    .busy  (busy),
    .cpol  (cfg_cpol),
    .start (xfer_start)
);

// File: tb/spi_master_ctl_test.sv
// Bench: a behavioural model schedules every edge and capture from the start
// cycle and is compared with the outputs and read data on every clock.
module spi_master_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        miso = 1'b0;
    logic [15:0] rdata;
    logic        sck, mosi, irq;
    logic [7:0]  cs_n;

    always #5 clk = ~clk;

    spi_master_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string tag = "R1";

    bit        m_busy = 0, m_sck = 0, m_mosi = 0, m_done = 0, m_pha = 0;
    bit [3:0]  m_ctrl = 0;
    bit [9:0]  m_rate = 10'h002;
    bit [1:0]  m_dly = 2'd1;
    bit [7:0]  m_rx = 0, m_cs_n = 8'hFF, m_byte = 0;
    bit [15:0] lfsr = 16'hACE1;
    int        et[16];
    int        ct[8];
    int        t_end = 0;

    // Period in core cycles from the rate word (R3, R4).
    function automatic int calc_period(bit [9:0] r);
        int m, d;
        if (r[7]) begin
            m = (r[3:0] == 0) ? 1 : int'(r[3:0]);
            d = m << r[6:4];
            if (d < 2) d = 2;
        end else begin
            m = (r[3:0] < 2) ? 2 : int'(r[3:0]);
            d = 2 * m;
        end
        return d;
    endfunction

    function automatic bit [15:0] model_read(bit [2:0] a);
        case (a)
            3'd0: return {12'b0, m_ctrl};
            3'd1: return {6'b0, m_rate};
            3'd2: return {14'b0, m_dly};
            3'd3: return {8'b0, m_rx};
            3'd4: return {15'b0, m_done};
            default: return 16'h0;
        endcase
    endfunction

    // Advance the model across one clock edge with this cycle's inputs.
    task automatic model_step(bit we, bit [2:0] a, bit [15:0] wd, bit mi);
        bit was_busy;
        int d, h1;
        was_busy = m_busy;
        if (we && a == 3'd0 && !wd[0] && m_busy) begin
            m_busy = 0;
            m_sck  = m_rate[8];
        end else if (m_busy) begin
            for (int k = 0; k < 16; k++) begin
                if (et[k] == cyc) begin
                    m_sck = ~m_sck;
                    if (m_pha && (k % 2 == 0)) m_mosi = m_byte[7 - k/2];
                    if (!m_pha && (k % 2 == 1) && k < 15) m_mosi = m_byte[7 - (k+1)/2];
                end
            end
            for (int j = 0; j < 8; j++) begin
                if (ct[j] == cyc) m_rx = {m_rx[6:0], mi};
            end
            if (cyc == t_end) begin
                m_busy = 0;
                m_done = 1;
            end
        end else begin
            m_sck = m_rate[8];
        end
        if (we) begin
            case (a)
                3'd0: begin
                    m_ctrl = wd[3:0];
                    m_cs_n = wd[0] ? ~(8'd1 << wd[3:1]) : 8'hFF;
                end
                3'd1: m_rate = wd[9:0];
                3'd2: m_dly = wd[1:0];
                3'd3: if (m_ctrl[0] && !was_busy) begin
                    d  = calc_period(m_rate);
                    h1 = d / 2;
                    for (int k = 0; k < 16; k++)
                        et[k] = cyc + (k/2)*d + ((k % 2 == 1) ? d : h1);
                    m_pha = m_rate[9];
                    for (int j = 0; j < 8; j++)
                        ct[j] = et[m_pha ? 2*j+1 : 2*j] + int'(m_dly);
                    t_end  = (et[15] > ct[7]) ? et[15] : ct[7];
                    m_byte = wd[7:0];
                    m_busy = 1;
                    m_done = 0;
                    if (!m_pha) m_mosi = wd[7];
                end
                default: ;
            endcase
        end
    endtask

    task automatic chk(string req, string what, logic [15:0] got, logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s (scenario %s) %s: actual %h expected %h at cycle %0d",
                     req, tag, what, got, exp, cyc);
        end
    endtask

    task automatic compare();
        chk("R5", "sck", 16'(sck), 16'(m_sck));
        chk("R6", "mosi", 16'(mosi), 16'(m_mosi));
        chk("R2", "cs_n", 16'(cs_n), 16'(m_cs_n));
        chk("R9", "irq", 16'(irq), 16'(m_done));
        chk("R11", "rdata", rdata, model_read(addr));
    endtask

    task automatic tick(bit we, bit [2:0] a, bit [15:0] wd);
        @(negedge clk);
        lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_en = we;
        addr  = a;
        wdata = wd;
        miso  = lfsr[0];
        model_step(we, a, wd, lfsr[0]);
        @(posedge clk);
        #1;
        compare();
        cyc++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 3'(cyc % 5), 16'h0);
    endtask

    function automatic bit [15:0] rate_word(bit pow, bit pol, bit pha, bit [2:0] e, bit [3:0] m);
        return {6'b0, pha, pol, pow, e, m};
    endfunction

    // One full byte with the given rate word and capture delay.
    task automatic xfer(bit [15:0] rw, bit [1:0] dl, bit [7:0] b);
        tick(1'b1, 3'd1, rw);
        tick(1'b1, 3'd2, {14'b0, dl});
        idle(2);
        tick(1'b1, 3'd3, {8'b0, b});
        while (m_busy) idle(1);
        idle(3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state at the ports and in the register reads
        addr = 3'd1;
        #1;
        chk("R1", "rate after reset", rdata, 16'h0002);
        chk("R1", "cs_n after reset", 16'(cs_n), 16'h00FF);
        chk("R1", "sck/mosi/irq after reset", {13'b0, sck, mosi, irq}, 16'h0);
        addr = 3'd2;
        #1;
        chk("R1", "delay after reset", rdata, 16'h0001);

        // R8: data write with the selects released is ignored
        tag = "R8";
        tick(1'b1, 3'd3, 16'h005A);
        idle(20);

        // R2: walk every select index, then release
        tag = "R2";
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, 3'd0, 16'((i << 1) | 1));
            idle(2);
        end
        tick(1'b1, 3'd0, 16'h0000);
        idle(2);
        tick(1'b1, 3'd0, 16'h000B);

        // R4: even-ratio encoding, including clamped and largest codes
        tag = "R4";
        foreach (m_byte[i]) ; // no-op keeps loop style uniform
        for (int h = 0; h < 5; h++) begin
            bit [3:0] hv;
            hv = (h == 0) ? 4'd0 : (h == 1) ? 4'd2 : (h == 2) ? 4'd3 : (h == 3) ? 4'd7 : 4'd15;
            for (int md = 0; md < 4; md++)
                xfer(rate_word(1'b0, md[1], md[0], 3'd0, hv), 2'd1, 8'(8'hA5 ^ (h * 37 + md)));
        end

        // R3: power-of-two encoding, including mantissa 0 and the floor of 2
        tag = "R3";
        for (int c = 0; c < 5; c++) begin
            bit [3:0] mv;
            bit [2:0] ev;
            mv = (c == 0) ? 4'd1 : (c == 1) ? 4'd0 : (c == 2) ? 4'd3 : (c == 3) ? 4'd5 : 4'd15;
            ev = (c == 3) ? 3'd2 : (c == 4) ? 3'd1 : 3'd0;
            for (int md = 0; md < 4; md++)
                xfer(rate_word(1'b1, md[1], md[0], ev, mv), 2'd1, 8'(8'h3C + c * 19 + md));
        end

        // R7 R6: capture delay swept against short and odd periods in every mode
        tag = "R7";
        for (int p = 0; p < 4; p++) begin
            bit [3:0] mv;
            mv = (p == 0) ? 4'd1 : (p == 1) ? 4'd3 : (p == 2) ? 4'd2 : 4'd4;
            for (int md = 0; md < 4; md++)
                for (int dl = 0; dl < 4; dl++)
                    xfer(rate_word(1'b1, md[1], md[0], 3'd0, mv), 2'(dl), 8'(8'hC3 ^ (p * 16 + md * 4 + dl)));
        end

        // R8: second data write while a byte is in flight is ignored
        tag = "R8";
        tick(1'b1, 3'd1, rate_word(1'b0, 1'b0, 1'b0, 3'd0, 4'd4));
        tick(1'b1, 3'd3, 16'h0096);
        idle(10);
        tick(1'b1, 3'd3, 16'h0069);
        while (m_busy) idle(1);
        idle(3);

        // R10: clearing the enable bit mid-byte aborts with no completion
        tag = "R10";
        tick(1'b1, 3'd1, rate_word(1'b0, 1'b1, 1'b1, 3'd0, 4'd4));
        tick(1'b1, 3'd3, 16'h00F0);
        idle(21);
        tick(1'b1, 3'd0, 16'h000A);
        idle(10);
        tick(1'b1, 3'd0, 16'h000B);
        // R9: a new start after the abort completes and raises the flag
        tag = "R9";
        xfer(rate_word(1'b0, 1'b1, 1'b1, 3'd0, 4'd2), 2'd2, 8'h81);
        tick(1'b1, 3'd0, 16'h0000);
        idle(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule